// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block watches the write cycles that a host issues to a byte-wide flash array. Each write carries an address and a byte. A command is accepted only after a fixed series of writes called the unlock keys. Once a series is complete, the block raises a single-clock pulse for the command it selected. The commands are byte program (with the target address and byte), sector erase (with the sector number), chip erase, autoselect entry and return to read mode. The block that owns the array and its timing consumes these pulses.

Each command opens with two key writes: AAh to key address A, then 55h to key address B. The third write picks the command. An erase also needs a second key pair after its setup byte, followed by a final selector write. A write that does not fit the current step quietly drops the decoder back to idle and issues no command. While the array reports that it is busy, writes are ignored and the decoder is held in idle.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, every command pulse output is low and the decoder is idle. Idle means the next accepted write must be a first key write before any command other than read-mode return can be issued.
- R2: Byte program uses four accepted writes: AAh to key address A (5555h), 55h to key address B (2AAAh), A0h to key address A, then any address and byte. The cycle after the fourth write, `prog_o` pulses and `prog_addr_o`/`prog_data_o` hold that fourth write's address and byte. In the fourth write, F0h is ordinary data.
- R3: Sector erase uses six accepted writes: AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, then 30h to any address. The cycle after the sixth write, `sect_erase_o` pulses and `sect_addr_o` holds the upper SECT_W bits (bits 18:10 by default) of the sixth address.
- R4: Chip erase uses the same sequence as R3, but the sixth write is 10h to key address A. The cycle after that write, `chip_erase_o` pulses. A 10h written to any other address in the sixth step issues nothing.
- R5: AAh@A, 55h@B, 90h@A pulses `autosel_o` in the cycle after the third write.
- R6: An accepted write of F0h in any step except the program-data step pulses `read_reset_o` the next cycle and returns the decoder to idle. This covers a lone F0h to any address and F0h@A as the third write.
- R7: A key address compares only the low MATCH_W (15) address bits. The upper address bits of a key write are don't-care.
- R8: An accepted write that matches neither the expected key nor a command for the current step returns the decoder to idle and pulses nothing. Completing a command afterwards needs the full series again from the first key.
- R9: While `busy_i` is high, writes produce no pulse and the decoder is forced to idle. A series interrupted by busy must restart from the first key.
- R10: Each command pulse lasts exactly one clock per accepted write, and at most one command output is high in any cycle.
- R11: A command pulse appears only in the cycle after an accepted write (`wr_en_i` high and `busy_i` low). Cycles with no write leave every pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Array busy; writes ignored, decoder held idle |
| wr_en_i | input | 1 | Write cycle strobe, one clock per write |
| wr_addr_i | input | ADDR_W (19) | Write address |
| wr_data_i | input | DATA_W (8) | Write byte |
| prog_o | output | 1 | Byte program pulse |
| prog_addr_o | output | ADDR_W (19) | Program target address |
| prog_data_o | output | DATA_W (8) | Program byte |
| sect_erase_o | output | 1 | Sector erase pulse |
| sect_addr_o | output | SECT_W (9) | Sector number to erase |
| chip_erase_o | output | 1 | Chip erase pulse |
| autosel_o | output | 1 | Autoselect entry pulse |
| read_reset_o | output | 1 | Return-to-read-mode pulse |

## Verification
The bench aims at several corner cases.

- A near miss in the middle of a series, such as a key written twice or AAh to the wrong address. A decoder that resynchronises instead of dropping to idle would later issue a command that should not exist.
- Key writes that carry high address bits. A full-width compare would reject these.
- F0h as program data. A design that gives F0h priority everywhere would issue a read reset and lose the program.
- A 10h selector written away from key address A. A sloppy decoder would start a chip erase here.
- Busy asserted partway through a series. A decoder that only blocks pulses, and keeps its step, would complete the command once busy drops.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
   localparam logic [7:0] CODE_KEY1  = 8'hAA;
   localparam logic [7:0] CODE_KEY2  = 8'h55;
   localparam logic [7:0] CODE_PROG  = 8'hA0;
   localparam logic [7:0] CODE_ESET  = 8'h80;
   localparam logic [7:0] CODE_AUTO  = 8'h90;
   localparam logic [7:0] CODE_READ  = 8'hF0;
   localparam logic [7:0] CODE_CHIP  = 8'h10;
   localparam logic [7:0] CODE_SECT  = 8'h30;

   typedef enum logic [2:0] {
      ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ESETUP, ST_EKEY1, ST_EKEY2
   } step_t;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_PROG, CMD_SECT, CMD_CHIP, CMD_AUTO, CMD_READ
   } cmd_t;

   typedef struct packed {
      logic at_a;
      logic at_b;
      logic d_key1;
      logic d_key2;
      logic d_prog;
      logic d_eset;
      logic d_auto;
      logic d_read;
      logic d_chip;
      logic d_sect;
   } match_t;
endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int MATCH_W = 15,
   parameter int DATA_W = 8,
   parameter logic [MATCH_W-1:0] KEY_A = 15'h5555,
   parameter logic [MATCH_W-1:0] KEY_B = 15'h2AAA
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output match_t            m_o
);
   logic [MATCH_W-1:0] low_addr;

   generate
      if (MATCH_W == ADDR_W) begin : g_full
         assign low_addr = addr_i;
      end else begin : g_part
         assign low_addr = addr_i[MATCH_W-1:0];
      end
   endgenerate

   always_comb begin
      m_o.at_a   = (low_addr == KEY_A);
      m_o.at_b   = (low_addr == KEY_B);
      m_o.d_key1 = (data_i == CODE_KEY1);
      m_o.d_key2 = (data_i == CODE_KEY2);
      m_o.d_prog = (data_i == CODE_PROG);
      m_o.d_eset = (data_i == CODE_ESET);
      m_o.d_auto = (data_i == CODE_AUTO);
      m_o.d_read = (data_i == CODE_READ);
      m_o.d_chip = (data_i == CODE_CHIP);
      m_o.d_sect = (data_i == CODE_SECT);
   end
endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
   import cmdseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   busy_i,
   input  logic   wr_en_i,
   input  match_t m_i,
   output step_t  step_o,
   output cmd_t   cmd_o
);
   step_t step_q, step_n;

   always_comb begin
      step_n = step_q;
      cmd_o  = CMD_NONE;
      if (busy_i) begin
         step_n = ST_IDLE;
      end else if (wr_en_i) begin
         step_n = ST_IDLE;
         if (step_q == ST_PROG) begin
            cmd_o = CMD_PROG;
         end else if (m_i.d_read) begin
            cmd_o = CMD_READ;
         end else begin
            unique case (step_q)
               ST_IDLE:   if (m_i.at_a && m_i.d_key1) step_n = ST_KEY1;
               ST_KEY1:   if (m_i.at_b && m_i.d_key2) step_n = ST_KEY2;
               ST_KEY2: begin
                  if (m_i.at_a && m_i.d_prog) step_n = ST_PROG;
                  else if (m_i.at_a && m_i.d_eset) step_n = ST_ESETUP;
                  else if (m_i.at_a && m_i.d_auto) cmd_o = CMD_AUTO;
               end
               ST_ESETUP: if (m_i.at_a && m_i.d_key1) step_n = ST_EKEY1;
               ST_EKEY1:  if (m_i.at_b && m_i.d_key2) step_n = ST_EKEY2;
               ST_EKEY2: begin
                  if (m_i.at_a && m_i.d_chip) cmd_o = CMD_CHIP;
                  else if (m_i.d_sect) cmd_o = CMD_SECT;
               end
               default:   step_n = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= ST_IDLE;
      else        step_q <= step_n;
   end

   assign step_o = step_q;

   assert_busy_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> (step_q == ST_IDLE));

   assert_idle_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en_i) && $past(step_q) == ST_IDLE) |-> (step_q == ST_IDLE));
endmodule

// File: rtl/cmdseq_out.sv
module cmdseq_out
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int SECT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              prog_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [DATA_W-1:0] prog_data_o,
   output logic              sect_o,
   output logic [SECT_W-1:0] sect_addr_o,
   output logic              chip_o,
   output logic              auto_o,
   output logic              read_o
);
   localparam int SECT_LSB = ADDR_W - SECT_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_o      <= 1'b0;
         sect_o      <= 1'b0;
         chip_o      <= 1'b0;
         auto_o      <= 1'b0;
         read_o      <= 1'b0;
         prog_addr_o <= '0;
         prog_data_o <= '0;
         sect_addr_o <= '0;
      end else begin
         prog_o <= (cmd_i == CMD_PROG);
         sect_o <= (cmd_i == CMD_SECT);
         chip_o <= (cmd_i == CMD_CHIP);
         auto_o <= (cmd_i == CMD_AUTO);
         read_o <= (cmd_i == CMD_READ);
         if (cmd_i == CMD_PROG) begin
            prog_addr_o <= addr_i;
            prog_data_o <= data_i;
         end
         if (cmd_i == CMD_SECT) sect_addr_o <= addr_i[ADDR_W-1:SECT_LSB];
      end
   end

   assert_single_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_o, sect_o, chip_o, auto_o, read_o}));

   assert_prog_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_o |-> (prog_addr_o == $past(addr_i) && prog_data_o == $past(data_i)));

   assert_sect_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sect_o |-> (sect_addr_o == $past(addr_i[ADDR_W-1:SECT_LSB])));
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int MATCH_W = 15,
   parameter int SECT_W = 9,
   parameter logic [MATCH_W-1:0] KEY_A = 15'h5555,
   parameter logic [MATCH_W-1:0] KEY_B = 15'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              prog_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [DATA_W-1:0] prog_data_o,
   output logic              sect_erase_o,
   output logic [SECT_W-1:0] sect_addr_o,
   output logic              chip_erase_o,
   output logic              autosel_o,
   output logic              read_reset_o
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("cmd_seq_decoder: command codes are bytes, DATA_W must be 8");
      end
      if (MATCH_W < 1 || MATCH_W > ADDR_W) begin : g_bad_match
         $error("cmd_seq_decoder: MATCH_W must lie in 1..ADDR_W");
      end
      if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
         $error("cmd_seq_decoder: SECT_W must lie in 1..ADDR_W");
      end
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("cmd_seq_decoder: key addresses must differ");
      end
   endgenerate

   match_t m;
   step_t  step;
   cmd_t   cmd;

   cmdseq_match #(
      .ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .DATA_W(DATA_W),
      .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_match (
      .addr_i(wr_addr_i), .data_i(wr_data_i), .m_o(m)
   );

   cmdseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wr_en_i(wr_en_i),
      .m_i(m), .step_o(step), .cmd_o(cmd)
   );

   cmdseq_out #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
      .addr_i(wr_addr_i), .data_i(wr_data_i),
      .prog_o(prog_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
      .sect_o(sect_erase_o), .sect_addr_o(sect_addr_o),
      .chip_o(chip_erase_o), .auto_o(autosel_o), .read_o(read_reset_o)
   );

   logic any_cmd;
   assign any_cmd = prog_o | sect_erase_o | chip_erase_o | autosel_o | read_reset_o;

   assert_cmd_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |-> ($past(wr_en_i) && !$past(busy_i)));

   assert_chip_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_o |-> ($past(wr_data_i) == CODE_CHIP &&
                        $past(wr_addr_i[MATCH_W-1:0]) == KEY_A));

   assert_auto_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      autosel_o |-> ($past(wr_data_i) == CODE_AUTO &&
                     $past(wr_addr_i[MATCH_W-1:0]) == KEY_A));

   assert_read_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      read_reset_o |-> ($past(wr_data_i) == CODE_READ));

   assert_no_pulse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> !any_cmd);

   assert_idle_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(step) != ST_PROG |-> !prog_o);
endmodule

// File: tb/tb_cmd_seq_decoder.sv
`timescale 1ns/1ps
module tb_cmd_seq_decoder;
   localparam int AW = 19;
   localparam int SW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic busy = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic prog, sect, chip, autos, rdrst;
   logic [AW-1:0] prog_addr;
   logic [7:0] prog_data;
   logic [SW-1:0] sect_addr;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   cmd_seq_decoder dut (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .prog_o(prog), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
      .sect_erase_o(sect), .sect_addr_o(sect_addr),
      .chip_erase_o(chip), .autosel_o(autos), .read_reset_o(rdrst)
   );

   // reference model state: 0 idle,1 key1,2 key2,3 prog,4 esetup,5 ekey1,6 ekey2
   int m_step = 0;
   logic e_prog, e_sect, e_chip, e_auto, e_rd;
   logic [AW-1:0] e_paddr;
   logic [7:0] e_pdata;
   logic [SW-1:0] e_saddr;

   task automatic model(input logic [AW-1:0] a, input logic [7:0] d, input logic b);
      logic ka, kb;
      ka = (a[14:0] == 15'h5555);
      kb = (a[14:0] == 15'h2AAA);
      {e_prog, e_sect, e_chip, e_auto, e_rd} = '0;
      if (b) begin
         m_step = 0;
      end else if (m_step == 3) begin
         e_prog = 1'b1; e_paddr = a; e_pdata = d; m_step = 0;
      end else if (d == 8'hF0) begin
         e_rd = 1'b1; m_step = 0;
      end else begin
         int nx;
         nx = 0;
         case (m_step)
            0: if (ka && d == 8'hAA) nx = 1;
            1: if (kb && d == 8'h55) nx = 2;
            2: begin
               if (ka && d == 8'hA0) nx = 3;
               else if (ka && d == 8'h80) nx = 4;
               else if (ka && d == 8'h90) e_auto = 1'b1;
            end
            4: if (ka && d == 8'hAA) nx = 5;
            5: if (kb && d == 8'h55) nx = 6;
            6: begin
               if (ka && d == 8'h10) e_chip = 1'b1;
               else if (d == 8'h30) begin e_sect = 1'b1; e_saddr = a[AW-1:AW-SW]; end
            end
            default: nx = 0;
         endcase
         m_step = nx;
      end
   endtask

   task automatic compare(input string tag);
      logic bad;
      checks++;
      bad = (prog !== e_prog) || (sect !== e_sect) || (chip !== e_chip) ||
            (autos !== e_auto) || (rdrst !== e_rd);
      if (e_prog && (prog_addr !== e_paddr || prog_data !== e_pdata)) bad = 1'b1;
      if (e_sect && sect_addr !== e_saddr) bad = 1'b1;
      if (bad) begin
         failures++;
         $display("FAIL %s: got p%b s%b c%b a%b r%b pa=%h pd=%h sa=%h exp p%b s%b c%b a%b r%b pa=%h pd=%h sa=%h",
                  tag, prog, sect, chip, autos, rdrst, prog_addr, prog_data, sect_addr,
                  e_prog, e_sect, e_chip, e_auto, e_rd, e_paddr, e_pdata, e_saddr);
      end
   endtask

   function automatic string tag_for(input logic b);
      if (b) return "R9";
      if (e_prog) return "R2";
      if (e_sect) return "R3";
      if (e_chip) return "R4";
      if (e_auto) return "R5";
      if (e_rd) return "R6";
      return "R8";
   endfunction

   // one write cycle; called just after a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic b = 1'b0,
                     input string tag = "");
      wr_addr = a; wr_data = d; busy = b; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
      model(a, d, b);
      compare(tag == "" ? tag_for(b) : tag);
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      {e_prog, e_sect, e_chip, e_auto, e_rd} = '0;
      compare(tag);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      case ($urandom_range(0, 4))
         0: return {4'($urandom), 15'h5555};
         1: return {4'($urandom), 15'h2AAA};
         2: return 19'h05555;
         3: return 19'h02AAA;
         default: return 19'($urandom);
      endcase
   endfunction

   function automatic logic [7:0] pick_data();
      case ($urandom_range(0, 9))
         0: return 8'hAA; 1: return 8'h55; 2: return 8'hA0; 3: return 8'h80;
         4: return 8'h90; 5: return 8'hF0; 6: return 8'h10; 7: return 8'h30;
         default: return 8'($urandom);
      endcase
   endfunction

   task automatic rand_seq();
      int kind;
      kind = $urandom_range(0, 4);
      wr(pick_addr() & 19'h78000 | 19'h05555, 8'hAA);
      wr({4'($urandom), 15'h2AAA}, 8'h55);
      case (kind)
         0: begin wr(19'h05555, 8'hA0); wr(pick_addr(), pick_data()); end
         1, 2: begin
            wr(19'h05555, 8'h80);
            if ($urandom_range(0, 7) == 0) wr(pick_addr(), pick_data());
            else wr({4'($urandom), 15'h5555}, 8'hAA);
            wr(19'h02AAA, 8'h55);
            if (kind == 1) wr(19'h05555, 8'h10);
            else wr(19'($urandom), 8'h30);
         end
         3: wr(19'h05555, 8'h90);
         default: wr(pick_addr(), pick_data(), $urandom_range(0, 5) == 0);
      endcase
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      e_paddr = '0; e_pdata = '0; e_saddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      idle_check("R1");
      // R1: idle means a command byte alone does nothing
      wr(19'h05555, 8'hA0, 1'b0, "R1");
      wr(19'h12345, 8'h77, 1'b0, "R1");
      // R2: program, F0 as data stays data
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
      wr(19'h7ABCD, 8'hF0, 1'b0, "R2");
      // R10: pulse drops after one clock
      idle_check("R10");
      // R3: sector erase
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
      wr(19'h7C400, 8'h30, 1'b0, "R3");
      // R4: chip erase; then 10h away from key A issues nothing
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
      wr(19'h05555, 8'h10, 1'b0, "R4");
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
      wr(19'h01234, 8'h10, 1'b0, "R4");
      // R5: autoselect
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90, 1'b0, "R5");
      // R6: lone F0 anywhere, and keyed F0
      wr(19'h3F00F, 8'hF0, 1'b0, "R6");
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hF0, 1'b0, "R6");
      // R7: key addresses with upper bits set
      wr(19'h7D555, 8'hAA, 1'b0, "R7"); wr(19'h4AAAA, 8'h55, 1'b0, "R7");
      wr(19'h35555, 8'h90, 1'b0, "R7");
      // R8: repeated key breaks the series; A0 must not arm
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hAA, 1'b0, "R8");
      wr(19'h05555, 8'hA0, 1'b0, "R8"); wr(19'h00100, 8'h12, 1'b0, "R8");
      // R9: busy mid-series forces restart
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55, 1'b1, "R9");
      wr(19'h05555, 8'hA0, 1'b0, "R9"); wr(19'h00200, 8'h34, 1'b0, "R9");
      wr(19'h05555, 8'hF0, 1'b1, "R9");
      // R11: no pulse without writes
      repeat (4) idle_check("R11");
      // random mix
      for (int i = 0; i < 400; i++) rand_seq();
      for (int i = 0; i < 3000; i++) begin
         wr(pick_addr(), pick_data(), $urandom_range(0, 9) == 0);
         if ($urandom_range(0, 15) == 0) idle_check("R11");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule